// File: doc/BRIEF.md
# Serial Port Clock Generator

This block produces the basic clock enable that paces both shift registers of a serial port able to run either as a synchronous shift interface or as an asynchronous character port. Its output, `bclk_en`, is a one-cycle enable in the system clock domain. Every high cycle stands for one tick of the serial basic clock.

In synchronous mode the port either drives its own shift clock or follows one supplied from outside. When it drives, the block halves an incoming baud tick stream with a toggle flop. It puts that toggle on the shift-clock pin with the output enable raised. When it follows, the external pin is synchronised and the chosen edge becomes the enable. In asynchronous mode a two-bit selector picks the source: the baud tick, every system clock cycle, a timer match pulse, or edges on the external pin.

Any change of the mode or of the source selector clears the toggle. The enable is also held low for one cycle, so the new setting starts on a clean phase.

Top module: `serclk_gen`

## Requirements
- R1: While `rst_n` is low, `bclk_en`, `sclk_out` and `sclk_oe` are all 0.
- R2: With `mode_async`=0 and `dir_in`=0 (synchronous, clock driven by the block), `sclk_out` inverts on every sampled `baud_tick`. `bclk_en` pulses once per two ticks, in the same cycle in which `sclk_out` falls.
- R3: `sclk_oe` is 1, one cycle after the inputs are sampled, exactly when `mode_async`=0 and `dir_in`=0. Whenever `sclk_oe` is 0, `sclk_out` is 0.
- R4: With `mode_async`=0 and `dir_in`=1 (clock taken from the pin), each edge of `ext_pin` of the selected polarity gives one `bclk_en` pulse (`edge_fall`=0 rising, 1 falling). The pulse is visible three clock edges after the pin changes: two synchroniser flops, then the output register.
- R5: With `mode_async`=1 and `src_sel`=2'b00, `bclk_en` is high in the cycle after each sampled `baud_tick` and at no other time.
- R6: With `mode_async`=1 and `src_sel`=2'b01, `bclk_en` is high in every cycle.
- R7: With `mode_async`=1 and `src_sel`=2'b10, `bclk_en` is high in the cycle after each sampled `tmr_match` and at no other time.
- R8: With `mode_async`=1 and `src_sel`=2'b11, each `ext_pin` edge of the polarity chosen by `edge_fall` gives exactly one `bclk_en` pulse.
- R9: When `mode_async` or `src_sel` differs from its value at the previous clock edge, the divide-by-2 toggle is cleared (`sclk_out` returns to 0). No `bclk_en` pulse is produced from that cycle's inputs.
- R10: Sources that are not selected have no effect: `tmr_match` in either synchronous setting, and `baud_tick` in synchronous clock-input mode, give no `bclk_en` pulse and leave `sclk_out` at 0 when not driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_async | input | 1 | 0 = synchronous shift mode, 1 = asynchronous character mode |
| dir_in | input | 1 | Synchronous mode: 0 = drive shift clock, 1 = take it from `ext_pin` |
| edge_fall | input | 1 | Pin edge used: 0 = rising, 1 = falling |
| src_sel | input | 2 | Asynchronous source: 00 baud tick, 01 system clock, 10 timer match, 11 pin |
| baud_tick | input | 1 | One-cycle tick from the baud-rate generator |
| tmr_match | input | 1 | One-cycle match pulse from a timer |
| ext_pin | input | 1 | External clock pin, asynchronous to `clk` |
| bclk_en | output | 1 | Basic clock enable, one system clock wide per tick |
| sclk_out | output | 1 | Shift-clock pin drive value |
| sclk_oe | output | 1 | Shift-clock pin output enable |

## Verification
The driven-clock mode is fed a run of baud ticks. The check separates a correct halving from a pass-through, or from a wrong phase of the toggle after a configuration change. Pin modes get square waves with both polarity selections. These show whether the edge chooser is wired the right way round and whether the synchroniser latency is three edges. Each asynchronous source is given its own pulse while the other sources are also pulsed. A wrong selector decode then shows up as extra or missing enables, and a forced selector change shows whether the one-cycle suppression is present.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

    typedef enum logic [1:0] {
        SRC_BAUD = 2'b00,
        SRC_SYS  = 2'b01,
        SRC_TMR  = 2'b10,
        SRC_PIN  = 2'b11
    } clk_src_e;

    typedef struct packed {
        logic     async_mode;
        clk_src_e src;
    } clk_cfg_t;

endpackage

// File: rtl/serclk_pin_edge.sv
module serclk_pin_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    // STAGES synchroniser flops plus one history flop for edge detection
    localparam int W = STAGES + 1;

    typedef struct packed {
        logic [W-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[W-2:0], pin};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sh <= {W{RST_LVL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign rise =  st_q.sh[W-2] & ~st_q.sh[W-1];
    assign fall = ~st_q.sh[W-2] &  st_q.sh[W-1];

endmodule

// File: rtl/serclk_div2.sv
module serclk_div2 (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    input  logic tick,
    output logic phase,
    output logic pulse
);
    typedef struct packed {
        logic tgl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        pulse = 1'b0;
        if (!run || clr) begin
            st_d.tgl = 1'b0;
        end else if (tick) begin
            st_d.tgl = ~st_q.tgl;
            pulse    = st_q.tgl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tgl <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.tgl;

endmodule

// File: rtl/serclk_src_mux.sv
module serclk_src_mux
    import serclk_pkg::*;
(
    input  clk_cfg_t cfg,
    input  logic     dir_in,
    input  logic     edge_fall,
    input  logic     baud_tick,
    input  logic     tmr_match,
    input  logic     pin_rise,
    input  logic     pin_fall,
    input  logic     div_pulse,
    output logic     raw
);
    logic pin_edge;

    always_comb begin
        pin_edge = edge_fall ? pin_fall : pin_rise;
        raw      = 1'b0;
        if (!cfg.async_mode) begin
            raw = dir_in ? pin_edge : div_pulse;
        end else begin
            case (cfg.src)
                SRC_BAUD: raw = baud_tick;
                SRC_SYS:  raw = 1'b1;
                SRC_TMR:  raw = tmr_match;
                SRC_PIN:  raw = pin_edge;
                default:  raw = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
    import serclk_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic PIN_IDLE    = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_async,
    input  logic       dir_in,
    input  logic       edge_fall,
    input  logic [1:0] src_sel,
    input  logic       baud_tick,
    input  logic       tmr_match,
    input  logic       ext_pin,
    output logic       bclk_en,
    output logic       sclk_out,
    output logic       sclk_oe
);
    typedef struct packed {
        clk_cfg_t cfg;
        logic     bclk;
        logic     oe;
    } st_t;

    st_t      st_d, st_q;
    clk_cfg_t cfg_now;
    logic     cfg_chg;
    logic     drive_clk;
    logic     pin_rise, pin_fall;
    logic     div_pulse, div_phase;
    logic     raw;

    always_comb begin
        cfg_now.async_mode = mode_async;
        cfg_now.src        = clk_src_e'(src_sel);
        cfg_chg            = (cfg_now != st_q.cfg);
        drive_clk          = !mode_async && !dir_in;
    end

    serclk_pin_edge #(
        .STAGES  (SYNC_STAGES),
        .RST_LVL (PIN_IDLE)
    ) pin_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    serclk_div2 div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (drive_clk),
        .clr   (cfg_chg),
        .tick  (baud_tick),
        .phase (div_phase),
        .pulse (div_pulse)
    );

    serclk_src_mux mux_i (
        .cfg       (cfg_now),
        .dir_in    (dir_in),
        .edge_fall (edge_fall),
        .baud_tick (baud_tick),
        .tmr_match (tmr_match),
        .pin_rise  (pin_rise),
        .pin_fall  (pin_fall),
        .div_pulse (div_pulse),
        .raw       (raw)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cfg  = cfg_now;
        st_d.bclk = raw && !cfg_chg;
        st_d.oe   = drive_clk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg  <= '0;
            st_q.bclk <= 1'b0;
            st_q.oe   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk_en  = st_q.bclk;
    assign sclk_out = div_phase;
    assign sclk_oe  = st_q.oe;

endmodule

// File: rtl/serclk_gen_chk.sv
module serclk_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_async,
    input logic       dir_in,
    input logic [1:0] src_sel,
    input logic       baud_tick,
    input logic       tmr_match,
    input logic       bclk_en,
    input logic       sclk_out,
    input logic       sclk_oe
);

    AST_DRIVEN_PULSE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_en && $past(!mode_async && !dir_in)) |-> $fell(sclk_out)); // R2

    AST_IDLE_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_oe |-> !sclk_out); // R3

    AST_OE_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sclk_oe == $past(!mode_async && !dir_in))); // R3

    AST_CFG_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (($past(mode_async) != $past(mode_async, 2)) ||
                          ($past(src_sel) != $past(src_sel, 2)))) |-> !bclk_en); // R9

    AST_BAUD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) &&
         $past(mode_async && src_sel == 2'b00) &&
         $past(mode_async && src_sel == 2'b00, 2)) |-> (bclk_en == $past(baud_tick))); // R5

    AST_SYS_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) &&
         $past(mode_async && src_sel == 2'b01) &&
         $past(mode_async && src_sel == 2'b01, 2)) |-> bclk_en); // R6

    AST_TMR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) &&
         $past(mode_async && src_sel == 2'b10) &&
         $past(mode_async && src_sel == 2'b10, 2)) |-> (bclk_en == $past(tmr_match))); // R7

endmodule

bind serclk_gen serclk_gen_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_async (mode_async),
    .dir_in     (dir_in),
    .src_sel    (src_sel),
    .baud_tick  (baud_tick),
    .tmr_match  (tmr_match),
    .bclk_en    (bclk_en),
    .sclk_out   (sclk_out),
    .sclk_oe    (sclk_oe)
);

// File: tb/serclk_gen_tb_top.sv
module serclk_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_async = 1'b0;
    logic       dir_in = 1'b0;
    logic       edge_fall = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       baud_tick = 1'b0;
    logic       tmr_match = 1'b0;
    logic       ext_pin = 1'b1;
    logic       bclk_en, sclk_out, sclk_oe;

    int n_chk = 0;
    int n_fail = 0;
    int pulse_cnt = 0;
    int base = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serclk_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_async (mode_async),
        .dir_in     (dir_in),
        .edge_fall  (edge_fall),
        .src_sel    (src_sel),
        .baud_tick  (baud_tick),
        .tmr_match  (tmr_match),
        .ext_pin    (ext_pin),
        .bclk_en    (bclk_en),
        .sclk_out   (sclk_out),
        .sclk_oe    (sclk_oe)
    );

    always @(posedge clk) begin
        if (rst_n && bclk_en) pulse_cnt <= pulse_cnt + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_baud(input int n, input int gap);
        repeat (n) begin
            @(negedge clk) baud_tick = 1'b1;
            @(negedge clk) baud_tick = 1'b0;
            wait_n(gap);
        end
    endtask

    task automatic tick_tmr(input int n, input int gap);
        repeat (n) begin
            @(negedge clk) tmr_match = 1'b1;
            @(negedge clk) tmr_match = 1'b0;
            wait_n(gap);
        end
    endtask

    task automatic pin_wave(input int n);
        repeat (n) begin
            @(negedge clk) ext_pin = 1'b0;
            wait_n(3);
            @(negedge clk) ext_pin = 1'b1;
            wait_n(3);
        end
        wait_n(5);
    endtask

    task automatic set_cfg(input logic m, input logic d, input logic [1:0] s, input logic e);
        @(negedge clk);
        mode_async = m;
        dir_in     = d;
        src_sel    = s;
        edge_fall  = e;
        wait_n(5);
    endtask

    task automatic t_reset();
        wait_n(3);
        check("R1 bclk_en", int'(bclk_en), 0);
        check("R1 sclk_out", int'(sclk_out), 0);
        check("R1 sclk_oe", int'(sclk_oe), 0);
        @(negedge clk) rst_n = 1'b1;
        wait_n(3);
    endtask

    task automatic t_sync_out();
        set_cfg(1'b0, 1'b0, 2'b00, 1'b0);
        check("R3 oe in driven mode", int'(sclk_oe), 1);
        check("R2 phase at start", int'(sclk_out), 0);
        base = pulse_cnt;
        tick_baud(1, 2);
        check("R2 phase after one tick", int'(sclk_out), 1);
        tick_baud(9, 2);
        wait_n(3);
        check("R2 pulses per ten ticks", pulse_cnt - base, 5);
        check("R2 phase after ten ticks", int'(sclk_out), 0);
        tick_baud(1, 2);
        check("R2 phase raised again", int'(sclk_out), 1);
        // selector change clears the toggle
        @(negedge clk) src_sel = 2'b10;
        @(negedge clk);
        check("R9 toggle cleared", int'(sclk_out), 0);
        check("R9 oe kept", int'(sclk_oe), 1);
        tick_baud(1, 2);
        check("R9 clean restart phase", int'(sclk_out), 1);
        base = pulse_cnt;
        tick_tmr(5, 1);
        wait_n(3);
        check("R10 timer ignored in driven mode", pulse_cnt - base, 0);
    endtask

    task automatic t_cfg_suppress();
        set_cfg(1'b1, 1'b0, 2'b00, 1'b0);
        check("R3 oe off in async mode", int'(sclk_oe), 0);
        @(negedge clk) src_sel = 2'b01;
        @(negedge clk);
        check("R9 no pulse on change cycle", int'(bclk_en), 0);
        @(negedge clk);
        check("R6 enable after change", int'(bclk_en), 1);
        base = pulse_cnt;
        wait_n(20);
        check("R6 every cycle", pulse_cnt - base, 20);
    endtask

    task automatic t_uart_baud();
        set_cfg(1'b1, 1'b0, 2'b00, 1'b0);
        base = pulse_cnt;
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
        check("R5 pulse one cycle after tick", int'(bclk_en), 1);
        @(negedge clk);
        check("R5 pulse one cycle wide", int'(bclk_en), 0);
        tick_baud(6, 1);
        tick_tmr(4, 1);
        wait_n(3);
        check("R5 count follows ticks only", pulse_cnt - base, 7);
    endtask

    task automatic t_uart_tmr();
        set_cfg(1'b1, 1'b0, 2'b10, 1'b0);
        base = pulse_cnt;
        @(negedge clk) tmr_match = 1'b1;
        @(negedge clk) tmr_match = 1'b0;
        check("R7 pulse one cycle after match", int'(bclk_en), 1);
        @(negedge clk);
        check("R7 pulse one cycle wide", int'(bclk_en), 0);
        tick_tmr(5, 2);
        tick_baud(4, 1);
        wait_n(3);
        check("R7 count follows matches only", pulse_cnt - base, 6);
    endtask

    task automatic t_sync_in();
        set_cfg(1'b0, 1'b1, 2'b00, 1'b0);
        check("R3 oe off in pin mode", int'(sclk_oe), 0);
        @(negedge clk) ext_pin = 1'b0;
        wait_n(6);
        @(negedge clk) ext_pin = 1'b1;
        @(negedge clk);
        check("R4 no pulse after one edge", int'(bclk_en), 0);
        @(negedge clk);
        check("R4 no pulse after two edges", int'(bclk_en), 0);
        @(negedge clk);
        check("R4 pulse after three edges", int'(bclk_en), 1);
        @(negedge clk);
        check("R4 pulse one cycle wide", int'(bclk_en), 0);
        base = pulse_cnt;
        pin_wave(4);
        check("R4 rising edges counted", pulse_cnt - base, 4);
        @(negedge clk) edge_fall = 1'b1;
        wait_n(2);
        base = pulse_cnt;
        pin_wave(3);
        check("R4 falling edges counted", pulse_cnt - base, 3);
        base = pulse_cnt;
        tick_baud(4, 1);
        tick_tmr(3, 1);
        wait_n(3);
        check("R10 ticks ignored in pin mode", pulse_cnt - base, 0);
        check("R10 pin drive stays low", int'(sclk_out), 0);
    endtask

    task automatic t_uart_pin();
        set_cfg(1'b1, 1'b0, 2'b11, 1'b0);
        base = pulse_cnt;
        pin_wave(5);
        check("R8 rising edges counted", pulse_cnt - base, 5);
        @(negedge clk) edge_fall = 1'b1;
        wait_n(2);
        base = pulse_cnt;
        pin_wave(2);
        tick_baud(3, 1);
        wait_n(3);
        check("R8 falling edges only", pulse_cnt - base, 2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sync_out();
        t_cfg_suppress();
        t_uart_baud();
        t_uart_tmr();
        t_sync_in();
        t_uart_pin();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule